// File: doc/BRIEF.md
# Planar Write Datapath

This block turns one host byte into the 32-bit word that is written across four 8-bit planes of a planar frame buffer. The byte passes through a right rotator, then a write-mode stage that may substitute per-plane set/reset colours, expand a 4-bit colour, or pass the display latch straight through. A two-operand logic stage then combines that word with the 32-bit display latch. A final per-bit select mask chooses, bit by bit, between the logic result and the latch.

Control values (rotate count, write mode, set/reset colour, set/reset enables, logic function and bit mask) are sampled together with the host byte on a write strobe. The resulting word appears on the output one clock later, with a one-cycle valid pulse. The latch contents come from the read side of the frame-buffer controller. Plane enables and address mapping are applied elsewhere.

Top module: `planar_write_dp`

## Requirements
- R1: In modes 0 and 3 the host byte is rotated right by `rot_count` positions (0 to 7) before use. Bit i of the rotated byte equals host bit (i + rot_count) mod 8.
- R2: Mode 0 (`wr_mode` = 2'b00): the data for plane b (output bits [8b+7:8b]) is all copies of `set_rst[b]` when `set_rst_en[b]` is 1, and the rotated host byte otherwise. The mask is `bit_mask`.
- R3: Mode 1 (`wr_mode` = 2'b01): the output word equals `latch_word`. Host byte, logic function and bit mask have no effect.
- R4: Mode 2 (`wr_mode` = 2'b10): every bit of plane b's data equals unrotated `host_byte[b]` for b = 0..3. The mask is `bit_mask`.
- R5: Mode 3 (`wr_mode` = 2'b11): every bit of plane b's data equals `set_rst[b]`. The mask is the rotated host byte ANDed with `bit_mask`.
- R6: Outside mode 1, the data is combined with the latch by `logic_fn`: 2'b00 data, 2'b01 data AND latch, 2'b10 data OR latch, 2'b11 data XOR latch.
- R7: Outside mode 1, output bit 8b+n takes the logic result when mask bit n is 1, and latch bit 8b+n when it is 0, for every plane b.
- R8: A write strobe in cycle t produces the computed word on `out_word` and a one-cycle high `out_valid` after the clock edge that ends cycle t. `out_valid` is low in any cycle that follows a cycle with no strobe.
- R9: `out_word` keeps its value across cycles with no write strobe, whatever the other inputs do.
- R10: Synchronous reset clears `out_word` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe; samples all data and control inputs |
| host_byte | input | 8 | Byte written by the host |
| latch_word | input | 32 | Display latch contents, plane b in bits [8b+7:8b] |
| rot_count | input | 3 | Right-rotate amount for the host byte |
| wr_mode | input | 2 | Write mode 0..3 |
| set_rst | input | 4 | Per-plane set/reset colour bits |
| set_rst_en | input | 4 | Per-plane set/reset enables (mode 0) |
| logic_fn | input | 2 | Combine function: copy, AND, OR, XOR |
| bit_mask | input | 8 | Per-bit select between logic result and latch |
| out_word | output | 32 | Registered frame-buffer write word |
| out_valid | output | 1 | One-cycle pulse marking a new `out_word` |

## Verification
Mode 3 is the hardest situation to reach. There the host byte is not data: after rotation it becomes part of the mask. A fault that swaps the mask source or skips the rotation only shows when the rotate amount, bit mask and latch all differ in the right bit positions. The bench sweeps every write mode, logic function, rotate amount, set/reset colour and enable pattern. It pairs each combination with a freshly scrambled host byte, latch and bit mask, so every mask bit meets both a latch 0 and a latch 1 across the run. Between writes it changes every input without a strobe and checks that the output holds.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int PLANES = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = PLANES * LANE_W;
    localparam int ROT_W  = $clog2(LANE_W);

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PLANES-1:0] plane_vec_t;

    typedef enum logic [1:0] {
        WM_SUBST  = 2'b00,
        WM_LATCH  = 2'b01,
        WM_EXPAND = 2'b10,
        WM_FILL   = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        LF_COPY = 2'b00,
        LF_AND  = 2'b01,
        LF_OR   = 2'b10,
        LF_XOR  = 2'b11
    } lfn_e;

    // Data, select mask and bypass flag leaving the write-mode stage
    typedef struct packed {
        word_t data;
        lane_t mask;
        logic  bypass;
    } stage_t;

    function automatic lane_t rot_right(lane_t v, logic [ROT_W-1:0] n);
        logic [2*LANE_W-1:0] dbl;
        dbl = {v, v} >> n;
        return dbl[LANE_W-1:0];
    endfunction

    function automatic word_t combine(lfn_e f, word_t a, word_t b);
        case (f)
            LF_AND:  return a & b;
            LF_OR:   return a | b;
            LF_XOR:  return a ^ b;
            default: return a;
        endcase
    endfunction
endpackage

// File: rtl/pw_rotate.sv
module pw_rotate
    import pw_pkg::*;
(
    input  lane_t             din,
    input  logic [ROT_W-1:0]  count,
    output lane_t             dout
);
    always_comb begin
        dout = rot_right(din, count);
    end
endmodule

// File: rtl/pw_mode_unit.sv
module pw_mode_unit
    import pw_pkg::*;
(
    input  wmode_e     mode,
    input  lane_t      rotated,
    input  plane_vec_t host_low,
    input  plane_vec_t set_rst,
    input  plane_vec_t set_rst_en,
    input  lane_t      bit_mask,
    output stage_t     result
);
    word_t subst_w;
    word_t expand_w;
    word_t fill_w;

    for (genvar b = 0; b < PLANES; b++) begin : g_plane
        assign subst_w[b*LANE_W +: LANE_W]  = set_rst_en[b] ? {LANE_W{set_rst[b]}} : rotated;
        assign expand_w[b*LANE_W +: LANE_W] = {LANE_W{host_low[b]}};
        assign fill_w[b*LANE_W +: LANE_W]   = {LANE_W{set_rst[b]}};
    end

    always_comb begin
        result.bypass = 1'b0;
        result.mask   = bit_mask;
        result.data   = subst_w;
        case (mode)
            WM_LATCH: begin
                result.bypass = 1'b1;
                result.data   = '0;
            end
            WM_EXPAND: result.data = expand_w;
            WM_FILL: begin
                result.data = fill_w;
                result.mask = rotated & bit_mask;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pw_combine.sv
module pw_combine
    import pw_pkg::*;
(
    input  stage_t st,
    input  lfn_e   fn,
    input  word_t  latch,
    output word_t  dout
);
    word_t alu_w;
    word_t sel_w;

    assign alu_w = combine(fn, st.data, latch);

    for (genvar b = 0; b < PLANES; b++) begin : g_plane
        for (genvar n = 0; n < LANE_W; n++) begin : g_bit
            assign sel_w[b*LANE_W + n] = st.mask[n] ? alu_w[b*LANE_W + n]
                                                    : latch[b*LANE_W + n];
        end
    end

    assign dout = st.bypass ? latch : sel_w;
endmodule

// File: rtl/planar_write_dp.sv
module planar_write_dp
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [7:0]  host_byte,
    input  logic [31:0] latch_word,
    input  logic [2:0]  rot_count,
    input  logic [1:0]  wr_mode,
    input  logic [3:0]  set_rst,
    input  logic [3:0]  set_rst_en,
    input  logic [1:0]  logic_fn,
    input  logic [7:0]  bit_mask,
    output logic [31:0] out_word,
    output logic        out_valid
);
    lane_t  rotated;
    stage_t mode_st;
    word_t  next_word;

    pw_rotate u_rot (
        .din   (host_byte),
        .count (rot_count),
        .dout  (rotated)
    );

    pw_mode_unit u_mode (
        .mode       (wmode_e'(wr_mode)),
        .rotated    (rotated),
        .host_low   (host_byte[PLANES-1:0]),
        .set_rst    (set_rst),
        .set_rst_en (set_rst_en),
        .bit_mask   (bit_mask),
        .result     (mode_st)
    );

    pw_combine u_comb (
        .st    (mode_st),
        .fn    (lfn_e'(logic_fn)),
        .latch (latch_word),
        .dout  (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= wr_stb;
            if (wr_stb) begin
                out_word <= next_word;
            end
        end
    end
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_stb,
    input logic [7:0]  host_byte,
    input logic [31:0] latch_word,
    input logic [1:0]  wr_mode,
    input logic [1:0]  logic_fn,
    input logic [7:0]  bit_mask,
    input logic [31:0] out_word,
    input logic        out_valid
);
    a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> out_valid);

    a_r8_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> !out_valid);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(out_word));

    a_r3_latch_passthrough: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_mode == 2'b01) |=> out_word == $past(latch_word));

    a_r7_zero_mask_keeps_latch: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && bit_mask == 8'h00) |=> out_word == $past(latch_word));

    a_r4_expand_copy: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_mode == 2'b10 && logic_fn == 2'b00 && bit_mask == 8'hFF)
        |=> out_word == {{8{$past(host_byte[3])}}, {8{$past(host_byte[2])}},
                         {8{$past(host_byte[1])}}, {8{$past(host_byte[0])}}});

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (out_word == 32'h0 && !out_valid));
endmodule

bind planar_write_dp pw_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .host_byte  (host_byte),
    .latch_word (latch_word),
    .wr_mode    (wr_mode),
    .logic_fn   (logic_fn),
    .bit_mask   (bit_mask),
    .out_word   (out_word),
    .out_valid  (out_valid)
);

// File: tb/planar_write_dp_tb.sv
module planar_write_dp_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  host_byte = '0;
    logic [31:0] latch_word = '0;
    logic [2:0]  rot_count = '0;
    logic [1:0]  wr_mode = '0;
    logic [3:0]  set_rst = '0;
    logic [3:0]  set_rst_en = '0;
    logic [1:0]  logic_fn = '0;
    logic [7:0]  bit_mask = '0;
    logic [31:0] out_word;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5677;

    always #4 clk = ~clk;

    planar_write_dp dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .host_byte(host_byte),
        .latch_word(latch_word), .rot_count(rot_count), .wr_mode(wr_mode),
        .set_rst(set_rst), .set_rst_en(set_rst_en), .logic_fn(logic_fn),
        .bit_mask(bit_mask), .out_word(out_word), .out_valid(out_valid)
    );

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Bit-level reference built from the requirements
    function automatic logic [31:0] model(
        logic [7:0] h, logic [31:0] lat, int rc, int md,
        logic [3:0] sr, logic [3:0] sre, int fn, logic [7:0] bm);
        logic [31:0] res;
        logic [7:0]  r;
        logic [7:0]  msk;
        logic        d;
        logic        a;
        for (int i = 0; i < 8; i++) r[i] = h[(i + rc) % 8];
        msk = (md == 3) ? (r & bm) : bm;
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 8; n++) begin
                if (md == 0)      d = sre[b] ? sr[b] : r[n];
                else if (md == 2) d = h[b];
                else              d = sr[b];
                case (fn)
                    1:       a = d & lat[8*b+n];
                    2:       a = d | lat[8*b+n];
                    3:       a = d ^ lat[8*b+n];
                    default: a = d;
                endcase
                if (md == 1)   res[8*b+n] = lat[8*b+n];
                else           res[8*b+n] = msk[n] ? a : lat[8*b+n];
            end
        end
        return res;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scramble_inputs();
        seed = next_rand(seed); host_byte  = seed[7:0]; bit_mask = seed[15:8];
        rot_count = seed[18:16]; wr_mode = seed[20:19]; logic_fn = seed[22:21];
        set_rst = seed[26:23]; set_rst_en = seed[30:27];
        seed = next_rand(seed); latch_word = seed;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        string tag;
        logic [31:0] exp;
        logic [31:0] held;
        // R10: reset state
        repeat (3) @(negedge clk);
        check(out_word == 32'h0, "R10 out_word", out_word, 32'h0);
        check(out_valid == 1'b0, "R10 out_valid", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 idle valid", {31'h0, out_valid}, 32'h0);

        for (int md = 0; md < 4; md++) begin
            for (int fn = 0; fn < 4; fn++) begin
                for (int rc = 0; rc < 8; rc++) begin
                    for (int c = 0; c < 256; c++) begin
                        seed = next_rand(seed);
                        host_byte  = seed[7:0];
                        bit_mask   = (c % 17 == 0) ? 8'hFF : seed[15:8];
                        seed = next_rand(seed);
                        latch_word = seed;
                        wr_mode    = 2'(md);
                        logic_fn   = 2'(fn);
                        rot_count  = 3'(rc);
                        set_rst    = 4'(c);
                        set_rst_en = 4'(c >> 4);
                        exp = model(host_byte, latch_word, rc, md, set_rst,
                                    set_rst_en, fn, bit_mask);
                        case (md)
                            0:       tag = "R1 R2 R6 R7";
                            1:       tag = "R3";
                            2:       tag = "R4 R6 R7";
                            default: tag = "R1 R5 R6";
                        endcase
                        wr_stb = 1'b1;
                        @(negedge clk);
                        wr_stb = 1'b0;
                        check(out_word == exp, tag, out_word, exp);
                        check(out_valid == 1'b1, "R8 valid pulse", {31'h0, out_valid}, 32'h1);
                        if (c % 8 == 0) begin
                            held = out_word;
                            scramble_inputs();
                            @(negedge clk);
                            check(out_word == held, "R9 hold", out_word, held);
                            check(out_valid == 1'b0, "R8 pulse ends", {31'h0, out_valid}, 32'h0);
                        end
                    end
                end
            end
        end

        // R10: reset in the middle of operation
        scramble_inputs();
        wr_stb = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        rst = 1'b0;
        check(out_word == 32'h0, "R10 mid reset word", out_word, 32'h0);
        check(out_valid == 1'b0, "R10 mid reset valid", {31'h0, out_valid}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule